// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a compact processor that retires one instruction per clock. It runs a subset of the 32-bit base integer instruction set:
- register-register and register-immediate arithmetic, logic, compare and shift;
- upper-immediate loads, and adding an upper immediate to the program counter;
- the six two-register conditional branches;
- jump-and-link with a PC-relative or register-relative target;
- word loads and word stores.

The core fetches through a plain instruction port. It drives a word address and takes the 32-bit instruction back in the same cycle. Data memory is reached through an address, a write word, a write enable and four byte strobes. Writes take effect at the rising clock edge. Reads return combinationally in the same cycle.

Neither port carries a handshake. The core never stalls and applies no back-pressure, so memory must answer within the cycle that it is addressed. Two plain status outputs report each cycle whether the instruction now at the program counter is unsupported, or whether it tried to redirect to a target that is not word aligned.

Top module: `rv32_lite_core`

## Requirements
- R1: While `rst_n` is low, the program counter on `imem_addr` is 0 from the first rising edge onwards, and `dmem_we` stays 0. After release, fetching starts at address 0.
- R2: Register 0 always reads as zero. A write to it is discarded.
- R3: With opcode 0110011, funct3 selects the register-register operation: 000 add/sub, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 logical/arithmetic shift right, 110 or, 111 and. Instruction bit 30 set selects subtract and arithmetic shift; it is legal only with funct3 000 or 101. The result goes to rd.
- R4: With opcode 0010011, the same funct3 codes apply to rs1 and the sign-extended 12-bit immediate taken from bits 31:20. Shifts use the low 5 immediate bits. Bit 30 selects arithmetic right shift. Bits 31:25 must be zero for a left shift, and zero or 0100000 for a right shift.
- R5: Opcode 0110111 writes bits 31:12 into the top of rd with 12 zero bits below. Opcode 0010111 writes the program counter plus that same value.
- R6: Opcode 1100011 compares rs1 with rs2 by funct3: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. A taken branch moves to the PC plus the sign-extended, halfword-scaled split offset. The next instruction is not executed. funct3 010 and 011 are illegal.
- R7: Opcode 1101111 writes PC+4 to rd and jumps to the PC plus the sign-extended, halfword-scaled 20-bit offset. Opcode 1100111 with funct3 000 writes PC+4 to rd and jumps to rs1 plus the I-immediate, with bit 0 of the sum cleared.
- R8: The effective address of a load (opcode 0000011) or store (opcode 0100011), both with funct3 010, is rs1 plus the sign-extended offset. Stores take the offset split across bits 31:25 and 11:7. A load puts `dmem_addr` out and writes `dmem_rdata` to rd in the same cycle. A store drives `dmem_we`=1, `dmem_be`=1111 and `dmem_wdata`=rs2.
- R9: An instruction whose low two bits are not 11, whose opcode is outside the subset, or whose funct3/funct7 combination is not listed raises `illegal_insn`. It writes no register and no memory, and the PC advances by 4.
- R10: A taken branch or jump whose target has bit 1 set raises `misaligned_fetch`, writes no register, and leaves the program counter unchanged.
- R11: Every other instruction advances the program counter by 4. The program counter stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, takes effect at the rising edge |
| dmem_be | output | 4 | Byte strobes of the store |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, same cycle |
| illegal_insn | output | 1 | Current instruction is not in the subset |
| misaligned_fetch | output | 1 | Current redirect target is not word aligned |

## Verification
The main program mixes register and immediate operands built from a small positive and a small negative value. This separates signed from unsigned compares and logical from arithmetic shifts. Each branch kind runs once taken and once not taken. A skipped instruction that would change a counter shows whether a delay slot was wrongly executed.

Computed values are brought out by storing them. That makes every register result, including an attempted write to register 0 and a register left untouched by an illegal load, visible on the memory port. Two extra runs after fresh resets cover the jump-register path: one clears bit 0 of the target and one halts on an unaligned target. The register that the halting jump did not write is then stored and inspected.

// File: rtl/rvl_pkg.sv
package rvl_pkg;
  localparam logic [6:0] OP_REG    = 7'b0110011;
  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_LUI    = 7'b0110111;
  localparam logic [6:0] OP_AUIPC  = 7'b0010111;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [6:0] OP_JALR   = 7'b1100111;
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU, ALU_XOR,
    ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

  typedef enum logic [2:0] {IMM_I, IMM_S, IMM_B, IMM_U, IMM_J} imm_kind_e;

  typedef struct packed {
    logic    legal;
    logic    rf_we;
    logic    mem_we;
    logic    is_branch;
    logic    is_jal;
    logic    is_jalr;
    logic    a_is_pc;
    logic    b_is_imm;
    alu_op_e alu_op;
    wb_sel_e wb_sel;
  } ctrl_t;

  function automatic alu_op_e f3_to_op(input logic [2:0] f3, input logic alt);
    case (f3)
      3'b000:  return alt ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction
endpackage

// File: rtl/rvl_decode.sv
module rvl_decode
  import rvl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output ctrl_t           ctrl,
  output logic [XLEN-1:0] imm
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  imm_kind_e  kind;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  always_comb begin
    ctrl = '0;
    kind = IMM_I;
    case (opc)
      OP_REG: begin
        ctrl.legal  = (f7 == 7'h00) || (f7 == 7'h20 && (f3 == 3'b000 || f3 == 3'b101));
        ctrl.rf_we  = 1'b1;
        ctrl.alu_op = f3_to_op(f3, f7[5]);
      end
      OP_IMM: begin
        if (f3 == 3'b001)      ctrl.legal = (f7 == 7'h00);
        else if (f3 == 3'b101) ctrl.legal = (f7 == 7'h00) || (f7 == 7'h20);
        else                   ctrl.legal = 1'b1;
        ctrl.rf_we    = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.alu_op   = f3_to_op(f3, (f3 == 3'b101) && f7[5]);
      end
      OP_LUI: begin
        ctrl.legal = 1'b1; ctrl.rf_we = 1'b1; ctrl.b_is_imm = 1'b1;
        ctrl.alu_op = ALU_PASSB; kind = IMM_U;
      end
      OP_AUIPC: begin
        ctrl.legal = 1'b1; ctrl.rf_we = 1'b1; ctrl.b_is_imm = 1'b1;
        ctrl.a_is_pc = 1'b1; kind = IMM_U;
      end
      OP_BRANCH: begin
        ctrl.legal = (f3 != 3'b010) && (f3 != 3'b011);
        ctrl.is_branch = 1'b1; kind = IMM_B;
      end
      OP_JAL: begin
        ctrl.legal = 1'b1; ctrl.rf_we = 1'b1; ctrl.is_jal = 1'b1;
        ctrl.wb_sel = WB_LINK; kind = IMM_J;
      end
      OP_JALR: begin
        ctrl.legal = (f3 == 3'b000); ctrl.rf_we = 1'b1; ctrl.is_jalr = 1'b1;
        ctrl.wb_sel = WB_LINK;
      end
      OP_LOAD: begin
        ctrl.legal = (f3 == 3'b010); ctrl.rf_we = 1'b1; ctrl.b_is_imm = 1'b1;
        ctrl.wb_sel = WB_MEM;
      end
      OP_STORE: begin
        ctrl.legal = (f3 == 3'b010); ctrl.mem_we = 1'b1; ctrl.b_is_imm = 1'b1;
        kind = IMM_S;
      end
      default: ;
    endcase
    if (!ctrl.legal) ctrl = '0;
  end

  always_comb begin
    case (kind)
      IMM_S:   imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
      IMM_B:   imm = {{(XLEN-13){instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
      IMM_U:   imm = {{(XLEN-32){instr[31]}}, instr[31:12], 12'b0};
      IMM_J:   imm = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
      default: imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
    endcase
  end
endmodule

// File: rtl/rvl_regfile.sv
module rvl_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

  AST_RF_WRITEBACK: assert property (@(posedge clk)
    (we && waddr != '0) |=> (raddr_a != $past(waddr)) || (rdata_a == $past(wdata))); // R3
endmodule

// File: rtl/rvl_alu.sv
module rvl_alu
  import rvl_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int SW = $clog2(W);
  logic [SW-1:0] sh;
  assign sh = b[SW-1:0];

  always_comb begin
    case (op)
      ALU_SUB:   y = a - b;
      ALU_SLL:   y = a << sh;
      ALU_SLT:   y = W'($signed(a) < $signed(b));
      ALU_SLTU:  y = W'(a < b);
      ALU_XOR:   y = a ^ b;
      ALU_SRL:   y = a >> sh;
      ALU_SRA:   y = W'($signed(a) >>> sh);
      ALU_OR:    y = a | b;
      ALU_AND:   y = a & b;
      ALU_PASSB: y = b;
      default:   y = a + b;
    endcase
  end
endmodule

// File: rtl/rv32_lite_core.sv
module rv32_lite_core
  import rvl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREGS = 32,
  localparam int RAW = $clog2(NREGS),
  localparam int NBE = XLEN / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic [NBE-1:0]  dmem_be,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            illegal_insn,
  output logic            misaligned_fetch
);
  ctrl_t           ctrl;
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, imm, rs1_v, rs2_v;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, tgt_base, tgt_sum, tgt, wb_v;
  logic            cmp_true, take, redirect, mis, rf_we;

  rvl_decode #(.XLEN(XLEN)) u_dec (.instr(imem_data), .ctrl(ctrl), .imm(imm));

  rvl_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk(clk), .we(rf_we), .waddr(RAW'(imem_data[11:7])), .wdata(wb_v),
    .raddr_a(RAW'(imem_data[19:15])), .rdata_a(rs1_v),
    .raddr_b(RAW'(imem_data[24:20])), .rdata_b(rs2_v)
  );

  assign alu_a = ctrl.a_is_pc ? pc_q : rs1_v;
  assign alu_b = ctrl.b_is_imm ? imm : rs2_v;

  rvl_alu #(.W(XLEN)) u_alu (.op(ctrl.alu_op), .a(alu_a), .b(alu_b), .y(alu_y));

  always_comb begin
    case (imem_data[14:12])
      3'b000:  cmp_true = (rs1_v == rs2_v);
      3'b001:  cmp_true = (rs1_v != rs2_v);
      3'b100:  cmp_true = ($signed(rs1_v) < $signed(rs2_v));
      3'b101:  cmp_true = ($signed(rs1_v) >= $signed(rs2_v));
      3'b110:  cmp_true = (rs1_v < rs2_v);
      3'b111:  cmp_true = (rs1_v >= rs2_v);
      default: cmp_true = 1'b0;
    endcase
  end

  assign take     = ctrl.is_branch && cmp_true;
  assign tgt_base = ctrl.is_jalr ? rs1_v : pc_q;
  assign tgt_sum  = tgt_base + imm;
  assign tgt      = {tgt_sum[XLEN-1:1], tgt_sum[0] & ~ctrl.is_jalr};
  assign redirect = take || ctrl.is_jal || ctrl.is_jalr;
  assign mis      = redirect && tgt[1];
  assign pc_plus4 = pc_q + XLEN'(4);
  assign pc_d     = mis ? pc_q : (redirect ? tgt : pc_plus4);
  assign rf_we    = ctrl.rf_we && !mis && rst_n;

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  wb_v = dmem_rdata;
      WB_LINK: wb_v = pc_plus4;
      default: wb_v = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign imem_addr        = pc_q;
  assign dmem_addr        = alu_y;
  assign dmem_wdata       = rs2_v;
  assign dmem_we          = ctrl.mem_we && rst_n;
  assign dmem_be          = {NBE{dmem_we}};
  assign illegal_insn     = !ctrl.legal;
  assign misaligned_fetch = mis;

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_insn |-> (!dmem_we && !rf_we)); // R9
  AST_MISALIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned_fetch |=> (imem_addr == $past(imem_addr))); // R10
  AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00); // R11
  AST_STORE_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (dmem_be == {NBE{1'b1}})); // R8
endmodule

// File: tb/rv32_lite_core_test.sv
module rv32_lite_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, ill, mis;
  logic [3:0]  dmem_be;

  always #10 clk = ~clk;

  rv32_lite_core uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_be(dmem_be), .dmem_rdata(dmem_rdata),
    .illegal_insn(ill), .misaligned_fetch(mis)
  );

  logic [31:0] imem [128];
  logic [31:0] dmem [64];
  logic [31:0] mmem [64];
  logic [31:0] mregs [32];
  logic [31:0] mpc;
  int n_cmp = 0, n_bad = 0, cyc = 0, p = 0;

  assign imem_data  = imem[imem_addr[8:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all R): got %0d cycles expected under 5000", cyc);
      summary();
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  function automatic logic [31:0] r_t(input logic [6:0] f7, input logic [4:0] rs2, rs1,
                                      input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] i_t(input logic [31:0] im, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {im[11:0], rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] s_t(input logic [31:0] im, input logic [4:0] rs2, rs1);
    return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] b_t(input logic [31:0] im, input logic [4:0] rs2, rs1,
                                      input logic [2:0] f3);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] j_t(input logic [31:0] im, input logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] addi(input logic [4:0] rd, rs1, input logic [31:0] im);
    return i_t(im, rs1, 3'b000, rd, 7'b0010011);
  endfunction

  task automatic put(input logic [31:0] w);
    imem[p] = w; p++;
  endtask

  function automatic logic [31:0] ref_alu(input logic [2:0] f3, input logic alt,
                                          input logic [31:0] x, input logic [31:0] y);
    int sh;
    sh = int'(y[4:0]);
    case (f3)
      3'd0: return alt ? x - y : x + y;
      3'd1: return x << sh;
      3'd2: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      3'd3: return (x < y) ? 32'd1 : 32'd0;
      3'd4: return x ^ y;
      3'd5: return alt ? 32'($signed(x) >>> sh) : x >> sh;
      3'd6: return x | y;
      default: return x & y;
    endcase
  endfunction

  // Reference step: predicts the outputs of the current cycle, compares, then commits.
  task automatic model_cycle();
    logic [31:0] ins, a, b, iI, iS, iB, iU, iJ, res, nxt, tg, ea;
    logic [6:0] op, f7;
    logic [2:0] f3;
    logic [4:0] rd;
    logic legal, wr, jmp, e_we, e_ld, m;
    string tag;
    ins = imem[mpc[8:2]];
    op = ins[6:0]; f3 = ins[14:12]; f7 = ins[31:25]; rd = ins[11:7];
    a = mregs[ins[19:15]]; b = mregs[ins[24:20]];
    iI = 32'($signed(ins[31:20]));
    iS = 32'($signed({ins[31:25], ins[11:7]}));
    iB = 32'($signed({ins[31], ins[7], ins[30:25], ins[11:8], 1'b0}));
    iU = {ins[31:12], 12'h000};
    iJ = 32'($signed({ins[31], ins[19:12], ins[20], ins[30:21], 1'b0}));
    legal = 0; wr = 0; jmp = 0; e_we = 0; e_ld = 0; res = 0; tg = 0; ea = 0;
    nxt = mpc + 4; tag = "R9";
    case (op)
      7'h33: begin tag = "R3"; wr = 1; res = ref_alu(f3, f7[5], a, b);
        legal = (f7 == 0) || (f7 == 7'h20 && (f3 == 0 || f3 == 5)); end
      7'h13: begin tag = "R4"; wr = 1; res = ref_alu(f3, f3 == 5 && f7[5], a, iI);
        legal = (f3 == 1) ? (f7 == 0) : (f3 == 5) ? (f7 == 0 || f7 == 7'h20) : 1'b1; end
      7'h37: begin tag = "R5"; wr = 1; legal = 1; res = iU; end
      7'h17: begin tag = "R5"; wr = 1; legal = 1; res = mpc + iU; end
      7'h63: begin tag = "R6"; legal = (f3 != 2 && f3 != 3); tg = mpc + iB;
        case (f3)
          3'd0: jmp = (a == b);
          3'd1: jmp = (a != b);
          3'd4: jmp = ($signed(a) < $signed(b));
          3'd5: jmp = ($signed(a) >= $signed(b));
          3'd6: jmp = (a < b);
          default: jmp = (a >= b);
        endcase end
      7'h6f: begin tag = "R7"; legal = 1; jmp = 1; wr = 1; tg = mpc + iJ; res = mpc + 4; end
      7'h67: begin tag = "R7"; legal = (f3 == 0); jmp = 1; wr = 1;
        tg = (a + iI) & ~32'h1; res = mpc + 4; end
      7'h03: begin tag = "R8"; legal = (f3 == 2); wr = 1; e_ld = 1; ea = a + iI;
        res = mmem[ea[7:2]]; end
      7'h23: begin tag = "R8"; legal = (f3 == 2); e_we = 1; ea = a + iS; end
      default: legal = 0;
    endcase
    if (!legal) begin wr = 0; e_we = 0; e_ld = 0; jmp = 0; tag = "R9"; end
    m = jmp && tg[1];
    if (m) begin wr = 0; nxt = mpc; tag = "R10"; end
    else if (jmp) nxt = tg;
    chk({tag, "/R11 program counter"}, imem_addr, mpc);
    chk({tag, " illegal flag"}, 32'(ill), 32'(!legal));
    chk({tag, " misaligned flag"}, 32'(mis), 32'(m));
    chk({tag, " store enable"}, 32'(dmem_we), 32'(e_we));
    if (e_we || e_ld) chk({tag, " data address"}, dmem_addr, ea);
    if (e_we) begin
      chk({tag, " store data"}, dmem_wdata, b);
      chk({tag, " byte strobes"}, 32'(dmem_be), 32'hF);
    end
    if (wr && rd != 0) mregs[rd] = res;
    if (e_we) mmem[ea[7:2]] = b;
    mpc = nxt;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mpc = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pc in reset", imem_addr, 32'h0);
    chk("R1 no store in reset", 32'(dmem_we), 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      #1 model_cycle();
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) imem[i] = 32'h0000_0013;
    for (int i = 0; i < 64; i++) begin dmem[i] = 0; mmem[i] = 0; end
    for (int i = 0; i < 32; i++) mregs[i] = 0;
    // phase 1: arithmetic, branches, jumps, illegal codes, loads
    put(addi(1, 0, 5));
    put(addi(2, 0, -3));
    put(r_t(7'h00, 2, 1, 3'd0, 3));   // add
    put(r_t(7'h20, 2, 1, 3'd0, 4));   // sub
    put(r_t(7'h00, 1, 2, 3'd1, 5));   // sll
    put(r_t(7'h00, 1, 2, 3'd2, 6));   // slt
    put(r_t(7'h00, 1, 2, 3'd3, 7));   // sltu
    put(r_t(7'h00, 2, 1, 3'd4, 8));   // xor
    put(r_t(7'h00, 1, 2, 3'd5, 9));   // srl
    put(r_t(7'h20, 1, 2, 3'd5, 10));  // sra
    put(r_t(7'h00, 2, 1, 3'd6, 11));  // or
    put(r_t(7'h00, 2, 1, 3'd7, 12));  // and
    put(i_t(-2, 2, 3'd2, 13, 7'h13));
    put(i_t(-1, 1, 3'd3, 14, 7'h13));
    put(i_t(-1, 1, 3'd4, 15, 7'h13));
    put(i_t(32'h7f0, 1, 3'd6, 16, 7'h13));
    put(i_t(32'h0ff, 2, 3'd7, 17, 7'h13));
    put(i_t(31, 1, 3'd1, 18, 7'h13));
    put(i_t(4, 2, 3'd5, 19, 7'h13));
    put(i_t(32'h404, 2, 3'd5, 20, 7'h13));
    put({20'h80001, 5'd21, 7'b0110111});
    put({20'h00010, 5'd22, 7'b0010111});
    put(addi(0, 1, 7));               // R2 write to x0
    put(s_t(4, 0, 0));
    for (int r = 3; r <= 22; r++) put(s_t(4 * r, 5'(r), 0));
    put(addi(23, 0, 0));
    put(b_t(8, 1, 1, 3'd0)); put(addi(23, 23, 1));
    put(b_t(8, 1, 1, 3'd1)); put(addi(23, 23, 2));
    put(b_t(8, 1, 2, 3'd4)); put(addi(23, 23, 4));
    put(b_t(8, 1, 2, 3'd5)); put(addi(23, 23, 8));
    put(b_t(8, 1, 2, 3'd6)); put(addi(23, 23, 16));
    put(b_t(8, 1, 2, 3'd7)); put(addi(23, 23, 32));
    put(s_t(96, 23, 0));
    put(j_t(8, 24)); put(addi(23, 23, 100));
    put(s_t(100, 24, 0));
    put({20'h00000, 5'd25, 7'b0010111});
    put(i_t(12, 25, 3'd0, 26, 7'h67)); put(addi(23, 23, 1));
    put(s_t(104, 26, 0));
    put(32'h0000_0000);                // low bits 00
    put(r_t(7'h01, 2, 1, 3'd0, 23));   // unsupported funct7
    put(i_t(96, 0, 3'd0, 23, 7'h03));  // byte load, not in subset
    put(s_t(108, 23, 0));
    put(i_t(100, 0, 3'd2, 27, 7'h03));
    put(addi(27, 27, 1));
    put(s_t(112, 27, 0));
    put(addi(28, 0, 120));
    put(i_t(-20, 28, 3'd2, 29, 7'h03));
    put(s_t(116, 29, 28));
    put(b_t(6, 0, 0, 3'd0));           // taken, target off by 2
    do_reset();
    run(110);
    chk("R2 x0 stored", dmem[1], 32'h0);
    chk("R3 add result", dmem[3], 32'd2);
    chk("R3 arithmetic right shift", dmem[10], 32'hFFFF_FFFF);
    chk("R4 logical right shift imm", dmem[19], 32'h0FFF_FFFF);
    chk("R4 arithmetic right shift imm", dmem[20], 32'hFFFF_FFFF);
    chk("R5 upper immediate", dmem[21], 32'h8000_1000);
    chk("R6 branch skip count", dmem[24], 32'd26);
    chk("R9 illegal load left rd", dmem[27], 32'd26);
    chk("R10 held on bad branch", 32'(mis), 32'h1);
    // phase 2: register jumps
    for (int i = 0; i < 128; i++) imem[i] = 32'h0000_0013;
    p = 0;
    put(addi(6, 0, 77));
    put(addi(5, 0, 32'h11));
    put(i_t(0, 5, 3'd0, 7, 7'h67));   // target 0x10 after bit 0 cleared
    put(addi(6, 0, 1));
    put(s_t(0, 7, 0));
    put(addi(5, 0, 32'h1A));
    put(i_t(0, 5, 3'd0, 6, 7'h67));   // unaligned target
    do_reset();
    run(15);
    chk("R7 jump-register link", dmem[0], 32'h0000_000C);
    chk("R10 held on bad jump", imem_addr, 32'h18);
    // phase 3: store the register the bad jump must not have written
    imem[0] = s_t(4, 6, 0);
    do_reset();
    run(3);
    chk("R10 link not written", dmem[1], 32'd77);
    for (int i = 0; i < 64; i++) chk("R8 memory image", dmem[i], mmem[i]);
    summary();
  end
endmodule